// File: doc/BRIEF.md
# Sixteen-Channel Descriptor DMA Engine

This block moves data between memory locations on behalf of sixteen channels. It has one read-then-write datapath that all channels share. Each channel's setup is held in a small register file that software loads through a word-wide write port. The setup covers the source address, the destination address, the element count and a control word. The control word selects the element width, the source and destination increment, the circular window size, the completion interrupt and an optional follow-on channel.

A channel becomes pending on a peripheral request pulse, a software start pulse, or the completion of a channel that names it as its follow-on. When the engine is free, it takes the lowest-numbered pending channel. It copies that channel's setup into working registers and then performs one read and one write per element on a valid/ready memory master port. When the block finishes, or when software aborts it, the engine stores the advanced addresses and the remaining count back into the register file. A later start therefore resumes from where the channel stopped.

Top module: `dmx_engine`

## Requirements
- R1: After reset, no memory request is made, and `ch_busy` and `irq` are all zero.
- R2: When several channels are pending, the lowest-numbered channel is serviced first.
- R3: Each element is one read at the current source address, followed by one write to the current destination address. The written data is the read data masked to the element width. `m_size` carries the control field bits 1:0, where 0 means 8 bits, 1 means 16 bits and 2 means 32 bits. A request that is not accepted holds its address and direction.
- R4: After each element, an address whose increment bit is set advances by the element width in bytes (1, 2 or 4); an address whose bit is clear stays constant. The source increment is control bit 2 and the destination increment is control bit 3, and the two are chosen independently.
- R5: A nonzero circular field M (control bits 8:5) confines both addresses to an aligned window of 2^M bytes. Advancing past the window's top returns the address to the window base.
- R6: A start with count N makes exactly N read/write pairs. If control bit 4 is set, it then raises a single-cycle pulse on `irq[ch]`; if the bit is clear, no pulse is raised. At most one `irq` bit is high at a time.
- R7: A pulse on `hw_req[ch]` or `sw_start[ch]` makes the channel pending. When a channel completes with control bit 13 set, the channel named in control bits 12:9 becomes pending.
- R8: A pulse on `abort[ch]` stops that channel after the element in progress. No further access is made for it, no interrupt is raised, and its busy flag clears.
- R9: On completion or abort, the current addresses and the remaining count are written back to the register file. A later start continues from the written-back values.
- R10: A start whose stored count is zero completes without any memory access and raises its interrupt if control bit 4 is set.
- R11: An abort that arrives in the same cycle as the final element's write handshake suppresses the completion interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register-file write strobe |
| cfg_ch | input | 4 | Channel whose setup is written |
| cfg_sel | input | 2 | Field select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Field value |
| hw_req | input | 16 | Peripheral request pulses, one per channel |
| sw_start | input | 16 | Software start pulses, one per channel |
| abort | input | 16 | Abort pulses, one per channel |
| m_valid | output | 1 | Memory request valid |
| m_write | output | 1 | 1 for write, 0 for read |
| m_addr | output | 32 | Byte address |
| m_size | output | 2 | Element width code |
| m_wdata | output | 32 | Write data |
| m_ready | input | 1 | Memory accepts the request this cycle |
| m_rdata | input | 32 | Read data, valid while a read is accepted |
| irq | output | 16 | Completion pulses, one per channel |
| ch_busy | output | 16 | Channel pending or in service |

## Verification
The abort path and the normal completion path can act in the same cycle. This happens when software aborts a channel exactly as its last element's write is accepted. The bench counts accepted writes at the falling edge and raises `abort` precisely when the final write is presented. It then judges the outcome in three ways: no interrupt pulse, the busy flag cleared, and a later restart making no memory access because a zero remaining count was written back. A second case sets a peripheral request and a software start on two channels in the same cycle. The order of the first reads shows that the lower channel went first.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int NCH = 16;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int CW  = 16;
    localparam int MW  = 4;
    localparam int LW  = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} st_e;

    // Control word; bit positions are visible to software.
    typedef struct packed {
        logic          link_en;   // 13
        logic [LW-1:0] link_ch;   // 12:9
        logic [MW-1:0] wrap;      // 8:5
        logic          irq_en;    // 4
        logic          dinc;      // 3
        logic          sinc;      // 2
        logic [1:0]    size;      // 1:0
    } ctl_t;

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    lane_mask = DW'(8'hFF);
            2'd1:    lane_mask = DW'(16'hFFFF);
            default: lane_mask = '1;
        endcase
    endfunction
endpackage

// File: rtl/dmx_prio_pick.sv
module dmx_prio_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
        grant = any ? ({{(N-1){1'b0}}, 1'b1} << idx) : '0;
    end

    p_lowest_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (((req & (grant - {{(N-1){1'b0}}, 1'b1})) == '0) && ((grant & req) == grant)));
endmodule

// File: rtl/dmx_addr_step.sv
module dmx_addr_step #(
    parameter int AW = 32,
    parameter int MW = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          inc,
    input  logic [MW-1:0] wrap,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] bytes;
    logic [AW-1:0] sum;
    logic [AW-1:0] win;

    always_comb begin
        bytes = (size == 2'd0) ? AW'(1) : (size == 2'd1) ? AW'(2) : AW'(4);
        sum   = addr + bytes;
        win   = (wrap == '0) ? '1 : ((AW'(1) << wrap) - AW'(1));
        nxt   = inc ? ((addr & ~win) | (sum & win)) : addr;
    end
endmodule

// File: rtl/dmx_engine.sv
module dmx_engine #(
    parameter int NCH = dmx_pkg::NCH,
    parameter int AW  = dmx_pkg::AW,
    parameter int DW  = dmx_pkg::DW,
    parameter int CW  = dmx_pkg::CW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(NCH)-1:0]   cfg_ch,
    input  logic [1:0]               cfg_sel,
    input  logic [AW-1:0]            cfg_wdata,
    input  logic [NCH-1:0]           hw_req,
    input  logic [NCH-1:0]           sw_start,
    input  logic [NCH-1:0]           abort,
    output logic                     m_valid,
    output logic                     m_write,
    output logic [AW-1:0]            m_addr,
    output logic [1:0]               m_size,
    output logic [DW-1:0]            m_wdata,
    input  logic                     m_ready,
    input  logic [DW-1:0]            m_rdata,
    output logic [NCH-1:0]           irq,
    output logic [NCH-1:0]           ch_busy
);
    import dmx_pkg::*;

    localparam int CHW = $clog2(NCH);
    localparam int CTW = $bits(ctl_t);
    localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

    typedef struct packed {
        st_e            st;
        logic [CHW-1:0] ch;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic [CW-1:0]  cnt;
        ctl_t           ctl;
        logic [DW-1:0]  data;
        logic           aborted;
        logic [NCH-1:0] pend;
        logic [NCH-1:0] irq;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [AW-1:0] src_mem_d [NCH];
    logic [AW-1:0] src_mem_q [NCH];
    logic [AW-1:0] dst_mem_d [NCH];
    logic [AW-1:0] dst_mem_q [NCH];
    logic [CW-1:0] cnt_mem_d [NCH];
    logic [CW-1:0] cnt_mem_q [NCH];
    ctl_t          ctl_mem_d [NCH];
    ctl_t          ctl_mem_q [NCH];

    logic [NCH-1:0] pick_req, pick_gnt, grant, link_set;
    logic [CHW-1:0] pick_idx;
    logic           pick_any;
    logic           abort_cur;

    logic [AW-1:0] step_in  [2];
    logic          step_inc [2];
    logic [AW-1:0] step_out [2];

    assign pick_req = eng_q.pend & ~abort;

    dmx_prio_pick #(.N(NCH), .IW(CHW)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (pick_req),
        .grant (pick_gnt),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign step_in[0]  = eng_q.src;
    assign step_inc[0] = eng_q.ctl.sinc;
    assign step_in[1]  = eng_q.dst;
    assign step_inc[1] = eng_q.ctl.dinc;

    for (genvar g = 0; g < 2; g++) begin : g_step
        dmx_addr_step #(.AW(AW), .MW(MW)) u_step (
            .addr (step_in[g]),
            .size (eng_q.ctl.size),
            .inc  (step_inc[g]),
            .wrap (eng_q.ctl.wrap),
            .nxt  (step_out[g])
        );
    end

    assign abort_cur = abort[eng_q.ch];

    always_comb begin
        eng_d     = eng_q;
        eng_d.irq = '0;
        src_mem_d = src_mem_q;
        dst_mem_d = dst_mem_q;
        cnt_mem_d = cnt_mem_q;
        ctl_mem_d = ctl_mem_q;
        link_set  = '0;
        grant     = '0;
        m_valid   = 1'b0;
        m_write   = 1'b0;
        m_addr    = eng_q.src;
        m_wdata   = eng_q.data;

        if (cfg_we) begin
            case (cfg_sel)
                2'd0:    src_mem_d[cfg_ch] = cfg_wdata;
                2'd1:    dst_mem_d[cfg_ch] = cfg_wdata;
                2'd2:    cnt_mem_d[cfg_ch] = cfg_wdata[CW-1:0];
                default: ctl_mem_d[cfg_ch] = ctl_t'(cfg_wdata[CTW-1:0]);
            endcase
        end

        case (eng_q.st)
            ST_IDLE: begin
                if (pick_any) begin
                    grant         = pick_gnt;
                    eng_d.ch      = pick_idx;
                    eng_d.src     = src_mem_q[pick_idx];
                    eng_d.dst     = dst_mem_q[pick_idx];
                    eng_d.cnt     = cnt_mem_q[pick_idx];
                    eng_d.ctl     = ctl_mem_q[pick_idx];
                    eng_d.aborted = 1'b0;
                    eng_d.st      = (cnt_mem_q[pick_idx] == '0) ? ST_FIN : ST_RD;
                end
            end
            ST_RD: begin
                m_valid = 1'b1;
                m_addr  = eng_q.src;
                if (abort_cur) eng_d.aborted = 1'b1;
                if (m_ready) begin
                    eng_d.data = m_rdata & lane_mask(eng_q.ctl.size);
                    eng_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                m_valid = 1'b1;
                m_write = 1'b1;
                m_addr  = eng_q.dst;
                if (abort_cur) eng_d.aborted = 1'b1;
                if (m_ready) begin
                    eng_d.src = step_out[0];
                    eng_d.dst = step_out[1];
                    eng_d.cnt = eng_q.cnt - CW'(1);
                    eng_d.st  = (eng_q.aborted || abort_cur || eng_q.cnt == CW'(1))
                              ? ST_FIN : ST_RD;
                end
            end
            default: begin
                src_mem_d[eng_q.ch] = eng_q.src;
                dst_mem_d[eng_q.ch] = eng_q.dst;
                cnt_mem_d[eng_q.ch] = eng_q.cnt;
                if (!eng_q.aborted && !abort_cur) begin
                    if (eng_q.ctl.irq_en)  eng_d.irq = ONE << eng_q.ch;
                    if (eng_q.ctl.link_en) link_set  = ONE << eng_q.ctl.link_ch;
                end
                eng_d.st = ST_IDLE;
            end
        endcase

        eng_d.pend = ((eng_q.pend & ~grant) | hw_req | sw_start | link_set) & ~abort;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q     <= '0;
            src_mem_q <= '{default: '0};
            dst_mem_q <= '{default: '0};
            cnt_mem_q <= '{default: '0};
            ctl_mem_q <= '{default: '0};
        end else begin
            eng_q     <= eng_d;
            src_mem_q <= src_mem_d;
            dst_mem_q <= dst_mem_d;
            cnt_mem_q <= cnt_mem_d;
            ctl_mem_q <= ctl_mem_d;
        end
    end

    assign m_size  = eng_q.ctl.size;
    assign irq     = eng_q.irq;
    assign ch_busy = eng_q.pend | ((eng_q.st != ST_IDLE) ? (ONE << eng_q.ch) : '0);

    p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_write && m_ready) |=> (m_valid && m_write));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));

    p_abort_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_FIN && eng_q.aborted) |=> (irq == '0));

    p_const_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_write && m_ready && !eng_q.ctl.sinc) |=> (eng_q.src == $past(eng_q.src)));
endmodule

// File: tb/tb_dmx_engine.sv
module tb_dmx_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] hw_req = '0, sw_start = '0, abort = '0;
    logic        m_valid, m_write;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [1:0]  m_size;
    logic        m_ready = 1'b1;
    logic        stall_en = 1'b0;
    logic [15:0] irq, ch_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction
    assign m_rdata = pat(m_addr);

    always @(posedge clk) m_ready <= stall_en ? ~m_ready : 1'b1;

    dmx_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .hw_req(hw_req), .sw_start(sw_start), .abort(abort),
        .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
        .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .irq(irq), .ch_busy(ch_busy)
    );

    // access log, filled on accepted requests
    logic [31:0] log_addr [256];
    logic [31:0] log_data [256];
    logic        log_wr   [256];
    logic [1:0]  log_sz   [256];
    int          log_n = 0;
    int          irq_cnt [16];
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always @(negedge clk) begin
        if (rst_n && m_valid && m_ready && log_n < 256) begin
            log_addr[log_n] = m_addr;
            log_data[log_n] = m_wdata;
            log_wr[log_n]   = m_write;
            log_sz[log_n]   = m_size;
            log_n++;
        end
        for (int i = 0; i < 16; i++) if (irq[i]) irq_cnt[i]++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] a, input logic [1:0] sz,
                                        input bit inc, input logic [3:0] md);
        logic [31:0] b, w, off;
        if (!inc) return a;
        b = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        if (md == 0) return a + b;
        w   = 32'd1 << md;
        off = a % w;
        return (a - off) + ((off + b) % w);
    endfunction

    function automatic logic [31:0] msk(input logic [31:0] d, input logic [1:0] sz);
        return (sz == 0) ? (d & 32'hFF) : (sz == 1) ? (d & 32'hFFFF) : d;
    endfunction

    function automatic logic [31:0] mkctl(input logic [1:0] sz, input bit si, input bit di,
                                          input bit ie, input logic [3:0] md,
                                          input bit le, input logic [3:0] lc);
        return {18'd0, le, lc, md, ie, di, si, sz};
    endfunction

    task automatic wr_cfg(input logic [3:0] ch, input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load(input logic [3:0] ch, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] n, input logic [31:0] c);
        wr_cfg(ch, 2'd0, s);
        wr_cfg(ch, 2'd1, d);
        wr_cfg(ch, 2'd2, n);
        wr_cfg(ch, 2'd3, c);
    endtask

    task automatic clr();
        @(posedge clk);
        log_n = 0;
        for (int i = 0; i < 16; i++) irq_cnt[i] = 0;
    endtask

    task automatic start(input logic [3:0] ch);
        @(negedge clk);
        sw_start[ch] = 1'b1;
        @(negedge clk);
        sw_start = '0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while ((ch_busy != 0 || m_valid) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic expect_block(input int base, input logic [31:0] s0, input logic [31:0] d0,
                                input logic [1:0] sz, input bit si, input bit di,
                                input logic [3:0] md, input int n, input string atag);
        logic [31:0] s = s0, d = d0;
        for (int k = 0; k < n; k++) begin
            int r = base + 2 * k;
            chk(log_addr[r] == s && !log_wr[r] && log_sz[r] == sz, atag, "read address", log_addr[r], s);
            chk(log_addr[r+1] == d && log_wr[r+1], atag, "write address", log_addr[r+1], d);
            chk(log_data[r+1] == msk(pat(s), sz), "R3", "write data", log_data[r+1], msk(pat(s), sz));
            s = nxt(s, sz, si, md);
            d = nxt(d, sz, di, md);
        end
    endtask

    typedef struct packed {
        logic [3:0]  ch;
        logic [1:0]  sz;
        logic        si;
        logic        di;
        logic [3:0]  md;
        logic [15:0] cnt;
        logic [31:0] src;
        logic [31:0] dst;
        logic        ie;
        logic        st;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd0,  2'd2, 1'b1, 1'b1, 4'd0, 16'd4, 32'h0000_1000, 32'h0000_2000, 1'b1, 1'b0},
        '{4'd3,  2'd0, 1'b1, 1'b0, 4'd0, 16'd5, 32'h0000_1003, 32'h0000_3000, 1'b1, 1'b0},
        '{4'd7,  2'd1, 1'b0, 1'b1, 4'd0, 16'd3, 32'h0000_1100, 32'h0000_2202, 1'b0, 1'b0},
        '{4'd15, 2'd2, 1'b1, 1'b1, 4'd4, 16'd6, 32'h0000_4008, 32'h0000_5000, 1'b1, 1'b0},
        '{4'd9,  2'd0, 1'b0, 1'b0, 4'd0, 16'd1, 32'h0000_7777, 32'h0000_8888, 1'b1, 1'b0},
        '{4'd5,  2'd1, 1'b1, 1'b1, 4'd3, 16'd5, 32'h0000_6004, 32'h0000_9006, 1'b1, 1'b1}
    };

    initial begin
        repeat (140000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not finish actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) irq_cnt[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!m_valid, "R1", "m_valid after reset", 32'(m_valid), 0);
        chk(ch_busy == 0, "R1", "ch_busy after reset", 32'(ch_busy), 0);
        chk(irq == 0, "R1", "irq after reset", 32'(irq), 0);

        // table-driven blocks: R3 R4 R5 R6
        for (int v = 0; v < 6; v++) begin
            vec_t e = VECS[v];
            load(e.ch, e.src, e.dst, 32'(e.cnt), mkctl(e.sz, e.si, e.di, e.ie, e.md, 1'b0, 4'd0));
            stall_en = e.st;
            clr();
            start(e.ch);
            wait_idle();
            stall_en = 1'b0;
            chk(log_n == 2 * int'(e.cnt), "R6", "access count", 32'(log_n), 32'(2 * e.cnt));
            expect_block(0, e.src, e.dst, e.sz, e.si, e.di, e.md, int'(e.cnt),
                         (e.md != 0) ? "R5" : "R4");
            chk(irq_cnt[e.ch] == int'(e.ie), "R6", "irq pulses", 32'(irq_cnt[e.ch]), 32'(e.ie));
            chk(ch_busy == 0, "R6", "busy after block", 32'(ch_busy), 0);
        end

        // R9 resume channel 0 from written-back addresses
        wr_cfg(4'd0, 2'd2, 32'd2);
        clr();
        start(4'd0);
        wait_idle();
        chk(log_n == 4, "R9", "resume access count", 32'(log_n), 4);
        expect_block(0, 32'h1010, 32'h2010, 2'd2, 1'b1, 1'b1, 4'd0, 2, "R9");

        // R2 / R7: hw request on 6 and sw start on 2 in the same cycle
        load(4'd2, 32'h300, 32'h380, 1, mkctl(2'd2, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0));
        load(4'd6, 32'h600, 32'h680, 1, mkctl(2'd2, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0));
        clr();
        @(negedge clk);
        hw_req[6] = 1'b1;
        sw_start[2] = 1'b1;
        @(negedge clk);
        hw_req = '0;
        sw_start = '0;
        wait_idle();
        chk(log_addr[0] == 32'h300, "R2", "lower channel served first", log_addr[0], 32'h300);
        chk(log_addr[2] == 32'h600, "R7", "hw request channel served", log_addr[2], 32'h600);
        chk(irq_cnt[6] == 1, "R7", "hw request channel irq", 32'(irq_cnt[6]), 1);

        // R7 link from channel 1 to channel 4
        load(4'd1, 32'h100, 32'h180, 1, mkctl(2'd2, 1'b1, 1'b1, 1'b1, 4'd0, 1'b1, 4'd4));
        load(4'd4, 32'hA000, 32'hB000, 1, mkctl(2'd2, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0));
        clr();
        start(4'd1);
        wait_idle();
        chk(log_n == 4, "R7", "linked access count", 32'(log_n), 4);
        chk(log_addr[2] == 32'hA000, "R7", "linked channel read", log_addr[2], 32'hA000);
        chk(irq_cnt[4] == 1 && irq_cnt[1] == 1, "R7", "linked irqs", 32'(irq_cnt[4]), 1);

        // R10 zero count
        load(4'd10, 32'h10, 32'h20, 0, mkctl(2'd2, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0));
        clr();
        start(4'd10);
        wait_idle();
        chk(log_n == 0, "R10", "zero count accesses", 32'(log_n), 0);
        chk(irq_cnt[10] == 1, "R10", "zero count irq", 32'(irq_cnt[10]), 1);

        // R8 abort after second element
        load(4'd11, 32'hC000, 32'hD000, 8, mkctl(2'd2, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0));
        clr();
        start(4'd11);
        begin
            int wc = 0;
            for (int t = 0; t < 200 && wc < 2; t++) begin
                if (m_valid && m_write && m_ready) wc++;
                if (wc == 2) begin
                    abort[11] = 1'b1;
                    @(negedge clk);
                    abort = '0;
                end else begin
                    @(negedge clk);
                end
            end
        end
        wait_idle();
        chk(log_n == 4, "R8", "accesses before abort", 32'(log_n), 4);
        chk(irq_cnt[11] == 0, "R8", "no irq on abort", 32'(irq_cnt[11]), 0);
        chk(ch_busy == 0, "R8", "busy cleared by abort", 32'(ch_busy), 0);
        clr();
        start(4'd11);
        wait_idle();
        chk(log_n == 12, "R9", "remaining count after abort", 32'(log_n), 12);
        expect_block(0, 32'hC008, 32'hD008, 2'd2, 1'b1, 1'b1, 4'd0, 6, "R9");
        chk(irq_cnt[11] == 1, "R9", "irq after resumed finish", 32'(irq_cnt[11]), 1);

        // R11 abort on the final write handshake
        load(4'd12, 32'hE000, 32'hE100, 3, mkctl(2'd1, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0));
        clr();
        start(4'd12);
        begin
            int wc = 0;
            for (int t = 0; t < 200 && wc < 3; t++) begin
                if (m_valid && m_write && m_ready) wc++;
                if (wc == 3) begin
                    abort[12] = 1'b1;
                    @(negedge clk);
                    abort = '0;
                end else begin
                    @(negedge clk);
                end
            end
        end
        wait_idle();
        chk(log_n == 6, "R11", "all elements moved", 32'(log_n), 6);
        chk(irq_cnt[12] == 0, "R11", "irq suppressed", 32'(irq_cnt[12]), 0);
        chk(ch_busy == 0, "R11", "busy cleared", 32'(ch_busy), 0);
        clr();
        start(4'd12);
        wait_idle();
        chk(log_n == 0, "R11", "stored count is zero", 32'(log_n), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule